// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns two duties for an asynchronous DRAM array built from several ranks: it brings the memory up after power-on and then keeps every row alive with periodic refresh cycles of the kind where the column strobe falls before the row strobe. After reset it waits out the mandatory power-up pause. It then runs a short burst of priming refresh cycles. Only after that does it raise `ready`, which tells the access sequencer that normal reads and writes may begin.

Once the memory is ready, an interval timer produces one refresh demand per refresh slot. The block shares the strobe lines with the access sequencer through a request/grant pair. It raises `ref_req` and starts a cycle only on a clock edge where `ref_gnt` is also high. A demand that arrives while an access runs stays pending in a small saturating backlog. Pending demands are later issued back to back. During a refresh cycle the block drives all column strobes low first, then all row strobes, and keeps the write enable high. `ref_own` tells the surrounding multiplexer that the block owns the strobes.

All timing limits are given in nanoseconds as parameters. They are turned into whole clock cycles by rounding up.

Top module: `rfc_ctrl`

## Requirements
- R1: After reset is released, `ref_req` stays low and every strobe stays high for INIT_CYC = ceil(INIT_NS/CLK_NS) cycles. `ref_req` first rises in the cycle after the INIT_CYC-th rising edge.
- R2: Exactly PRIME_CYCLES refresh cycles (default 8) run before `ready` rises. `ready` rises when the last of them has completed RP_CYC cycles of precharge, and it never falls again until reset.
- R3: In each refresh cycle the column strobes go low exactly CSR_CYC = ceil(CSR_NS/CLK_NS) cycles before the row strobes fall. Before they fall, the row strobes have been high for at least CPN_CYC = ceil(CPN_NS/CLK_NS) cycles.
- R4: The column strobes stay low for exactly CHR_CYC = ceil(CHR_NS/CLK_NS) cycles after the row strobes fall. They then rise while the row strobes are still low.
- R5: The row strobes stay low for exactly RAS_CYC = ceil(RAS_NS/CLK_NS) cycles. Between two refresh cycles they stay high for at least RP_CYC = ceil(RP_NS/CLK_NS) cycles.
- R6: While `ref_own` is high, `we_n` is high. All LINES row strobes carry one value and all LINES column strobes carry one value, so every rank is refreshed in the same cycle.
- R7: A refresh cycle starts (`ref_own` rises) only after an edge at which both `ref_req` and `ref_gnt` were high. `ref_req` is low while `ref_own` is high. No strobe falls while the grant is withheld.
- R8: After `ready`, one refresh demand is produced every REF_CYC = ceil(REF_INT_NS/CLK_NS) cycles. Up to MAX_BACKLOG (default 4) unserved demands are kept and extra ones are dropped. The kept demands are issued back to back, with the row strobes high for RP_CYC+1+CPN_CYC+CSR_CYC cycles between cycles.
- R9: During reset all strobes and `we_n` are high, and `ref_req`, `ref_own` and `ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Grant from the access sequencer; high when no access is in flight |
| ref_req | output | 1 | Request for the strobe lines |
| ref_own | output | 1 | High while a refresh cycle drives the strobes |
| ready | output | 1 | Power-up sequence complete; normal traffic allowed |
| ras_n | output | LINES | Row strobes, active low, one per rank line |
| cas_n | output | LINES | Column strobes, active low, one per byte line |
| we_n | output | 1 | Write enable, held high for refresh |

## Verification
The timer's tick and the acceptance of a pending refresh can land on the same clock edge. The backlog must then stay at its count rather than gain or lose a demand. The bench provokes this by withholding the grant with randomly timed access bursts whose ends fall near refresh slots. It judges the result by comparing the number of refresh cycles over forty slots with the number of slots. In a second step, it withholds the grant over more than four slots and expects exactly four refresh cycles back to back once the grant returns.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_CSR,
    SQ_BOTH,
    SQ_HOLD,
    SQ_RP
  } sq_state_t;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Row-low time left once the column strobe has been released.
  function automatic int unsigned hold_after_chr(input int unsigned ras_c, input int unsigned chr_c);
    return (ras_c > chr_c) ? (ras_c - chr_c) : 1;
  endfunction

endpackage

// File: rtl/rfc_interval_timer.sv
module rfc_interval_timer #(
  parameter int unsigned PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= CW'(PERIOD - 1);
    end else if (en) begin
      if (cnt == '0) cnt <= CW'(PERIOD - 1);
      else           cnt <= cnt - 1'b1;
    end
  end

  assign tick = en && (cnt == '0);
endmodule

// File: rtl/rfc_backlog.sv
module rfc_backlog #(
  parameter int unsigned MAX_CNT = 4,
  localparam int unsigned CW = $clog2(MAX_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          nonzero
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10: if (count != CW'(MAX_CNT)) count <= count + 1'b1;
        2'b01: if (count != '0)           count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign nonzero = (count != '0);
endmodule

// File: rtl/rfc_init_seq.sv
module rfc_init_seq #(
  parameter int unsigned WAIT_CYC = 20000,
  parameter int unsigned PRIME    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic cyc_done,
  output logic wait_over,
  output logic prime_req,
  output logic ready
);
  localparam int unsigned WW = $clog2(WAIT_CYC + 1);
  localparam int unsigned PW = $clog2(PRIME + 1);

  logic [WW-1:0] wait_cnt;
  logic [PW-1:0] prime_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt   <= WW'(WAIT_CYC - 1);
      wait_over  <= 1'b0;
      prime_left <= PW'(PRIME);
      ready      <= 1'b0;
    end else begin
      if (!wait_over) begin
        if (wait_cnt == '0) wait_over <= 1'b1;
        else                wait_cnt  <= wait_cnt - 1'b1;
      end
      if (accept && prime_left != '0) prime_left <= prime_left - 1'b1;
      if (wait_over && prime_left == '0 && (cyc_done || PRIME == 0)) ready <= 1'b1;
    end
  end

  assign prime_req = wait_over && (prime_left != '0);
endmodule

// File: rtl/rfc_strobe_seq.sv
module rfc_strobe_seq
  import rfc_pkg::*;
#(
  parameter int unsigned CPN  = 1,
  parameter int unsigned CSR  = 1,
  parameter int unsigned CHR  = 1,
  parameter int unsigned HOLD = 5,
  parameter int unsigned RP   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic own,
  output logic ras_low,
  output logic cas_low,
  output logic done
);
  localparam int unsigned LMAX = max2(max2(CPN, CSR), max2(max2(CHR, HOLD), RP));
  localparam int unsigned CW   = $clog2(LMAX + 1);

  function automatic sq_state_t succ(input sq_state_t s);
    case (s)
      SQ_PRE:  return SQ_CSR;
      SQ_CSR:  return SQ_BOTH;
      SQ_BOTH: return SQ_HOLD;
      SQ_HOLD: return SQ_RP;
      default: return SQ_IDLE;
    endcase
  endfunction

  function automatic logic [CW-1:0] phase_len(input sq_state_t s);
    case (s)
      SQ_PRE:  return CW'(CPN - 1);
      SQ_CSR:  return CW'(CSR - 1);
      SQ_BOTH: return CW'(CHR - 1);
      SQ_HOLD: return CW'(HOLD - 1);
      SQ_RP:   return CW'(RP - 1);
      default: return '0;
    endcase
  endfunction

  sq_state_t     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else if (st == SQ_IDLE) begin
      if (start) begin
        st  <= SQ_PRE;
        cnt <= phase_len(SQ_PRE);
      end
    end else if (cnt == '0) begin
      st  <= succ(st);
      cnt <= phase_len(succ(st));
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign own     = (st != SQ_IDLE);
  assign ras_low = (st == SQ_BOTH) || (st == SQ_HOLD);
  assign cas_low = (st == SQ_CSR) || (st == SQ_BOTH);
  assign done    = (st == SQ_RP) && (cnt == '0);
endmodule

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
#(
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned INIT_NS      = 200000,
  parameter int unsigned PRIME_CYCLES = 8,
  parameter int unsigned REF_INT_NS   = 15600,
  parameter int unsigned CPN_NS       = 5,
  parameter int unsigned CSR_NS       = 5,
  parameter int unsigned CHR_NS       = 10,
  parameter int unsigned RAS_NS       = 60,
  parameter int unsigned RP_NS        = 40,
  parameter int unsigned LINES        = 4,
  parameter int unsigned MAX_BACKLOG  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_own,
  output logic             ready,
  output logic [LINES-1:0] ras_n,
  output logic [LINES-1:0] cas_n,
  output logic             we_n
);
  localparam int unsigned INIT_CYC = ns_to_cycles(INIT_NS, CLK_NS);
  localparam int unsigned REF_CYC  = ns_to_cycles(REF_INT_NS, CLK_NS);
  localparam int unsigned CPN_CYC  = ns_to_cycles(CPN_NS, CLK_NS);
  localparam int unsigned CSR_CYC  = ns_to_cycles(CSR_NS, CLK_NS);
  localparam int unsigned CHR_CYC  = ns_to_cycles(CHR_NS, CLK_NS);
  localparam int unsigned RAS_CYC  = max2(ns_to_cycles(RAS_NS, CLK_NS), CHR_CYC + 1);
  localparam int unsigned RP_CYC   = ns_to_cycles(RP_NS, CLK_NS);
  localparam int unsigned HOLD_CYC = hold_after_chr(RAS_CYC, CHR_CYC);
  localparam int unsigned BLW      = $clog2(MAX_BACKLOG + 1);

  // Named internal events, visible to the bound checker.
  logic           tick;
  logic           accept;
  logic           cyc_done;
  logic           wait_over;
  logic           prime_req;
  logic           bl_nz;
  logic [BLW-1:0] bl_count;
  logic           ras_low;
  logic           cas_low;

  rfc_init_seq #(.WAIT_CYC(INIT_CYC), .PRIME(PRIME_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cyc_done(cyc_done),
    .wait_over(wait_over), .prime_req(prime_req), .ready(ready)
  );

  rfc_interval_timer #(.PERIOD(REF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(ready), .tick(tick)
  );

  rfc_backlog #(.MAX_CNT(MAX_BACKLOG)) u_backlog (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(accept && ready),
    .count(bl_count), .nonzero(bl_nz)
  );

  rfc_strobe_seq #(
    .CPN(CPN_CYC), .CSR(CSR_CYC), .CHR(CHR_CYC), .HOLD(HOLD_CYC), .RP(RP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .own(ref_own),
    .ras_low(ras_low), .cas_low(cas_low), .done(cyc_done)
  );

  assign ref_req = !ref_own && (prime_req || (ready && bl_nz));
  assign accept  = ref_req && ref_gnt;
  assign we_n    = 1'b1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign ras_n[g] = ~ras_low;
    assign cas_n[g] = ~cas_low;
  end
endmodule

// File: rtl/rfc_ctrl_chk.sv
module rfc_ctrl_chk #(
  parameter int unsigned LINES   = 4,
  parameter int unsigned RAS_CYC = 6,
  parameter int unsigned MAX_BL  = 4,
  parameter int unsigned BLW     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic             ref_gnt,
  input logic             ref_own,
  input logic             ready,
  input logic             wait_over,
  input logic [LINES-1:0] ras_n,
  input logic [LINES-1:0] cas_n,
  input logic [BLW-1:0]   bl_count
);
  logic [15:0] lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                          lo_run <= '0;
    else if (!ras_n[0] && lo_run != '1)  lo_run <= lo_run + 1'b1;
    else if (ras_n[0])                   lo_run <= '0;
  end

  p_quiet_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_over |-> (ras_n == {LINES{1'b1}} && cas_n == {LINES{1'b1}} && !ref_req));

  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_cas_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> $past(cas_n[0] == 1'b0));

  p_cas_up_under_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n[0]) |-> !ras_n[0]);

  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> (lo_run == 16'(RAS_CYC)));

  p_lines_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == {LINES{ras_n[0]}}) && (cas_n == {LINES{cas_n[0]}}));

  p_start_on_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_own) |-> $past(ref_req && ref_gnt));

  p_no_req_when_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_own |-> !ref_req);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bl_count <= BLW'(MAX_BL));
endmodule

bind rfc_ctrl rfc_ctrl_chk #(
  .LINES(LINES), .RAS_CYC(RAS_CYC), .MAX_BL(MAX_BACKLOG), .BLW(BLW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
  .ref_own(ref_own), .ready(ready), .wait_over(wait_over),
  .ras_n(ras_n), .cas_n(cas_n), .bl_count(bl_count)
);

// File: tb/sim_rfc_ctrl.sv
module sim_rfc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_NS    = 3000;
  localparam int REF_NS     = 2000;
  localparam int LINES      = 4;
  localparam int PRIME_B    = 8;
  localparam int MAXBL_B    = 4;
  localparam int WD_CYCLES  = 150000;

  function automatic int cyc_of(input int ns);
    int q;
    q = ns / CLK_PERIOD;
    if (ns % CLK_PERIOD != 0) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  localparam int INIT_B = cyc_of(INIT_NS);
  localparam int P_B    = cyc_of(REF_NS);
  localparam int CPN_B  = cyc_of(5);
  localparam int CSR_B  = cyc_of(5);
  localparam int CHR_B  = cyc_of(10);
  localparam int RAS_B  = cyc_of(60);
  localparam int RP_B   = cyc_of(40);
  localparam int GAP_B  = RP_B + 1 + CPN_B + CSR_B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt, ref_req, ref_own, ready, we_n;
  logic [LINES-1:0] ras_n, cas_n;

  logic busy = 1'b0, hold = 1'b0;
  assign ref_gnt = !hold && !busy;

  rfc_ctrl #(.INIT_NS(INIT_NS), .REF_INT_NS(REF_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_own(ref_own), .ready(ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Monitor: samples at the falling edge.
  bit prev_r = 1, prev_c = 1, prev_req = 0, seen_req = 0, seen_ready = 0, first_fall = 1;
  int hi_run = 0, lo_run = 0, cas_lo = 0, both = 0;
  int falls_pre_ready = 0;
  bit b2b_win = 0, rnd_on = 0;
  int b2b_n = 0, rnd_falls = 0;

  always @(negedge clk) begin
    bit r, c;
    if (rst_n) begin
      r = ras_n[0];
      c = cas_n[0];
      if (ref_req && !prev_req && !seen_req) begin
        seen_req = 1;
        chk(cyc == INIT_B, "R1 first request cycle", cyc, INIT_B);
      end
      if (ref_own) begin
        chk(we_n == 1'b1, "R6 we_n high during refresh", int'(we_n), 1);
        chk(ras_n == {LINES{r}} && cas_n == {LINES{c}}, "R6 lines agree",
            int'({ras_n, cas_n}), int'({{LINES{r}}, {LINES{c}}}));
        chk(!ref_req, "R7 request low while owning", int'(ref_req), 0);
      end
      if (!r || !c) chk(!busy, "R7 strobe during access", int'(busy), 0);
      if (!r && prev_r) begin
        chk(cas_lo == CSR_B, "R3 cas-to-ras lead", cas_lo, CSR_B);
        if (first_fall) chk(cyc >= INIT_B, "R1 first row strobe after pause", cyc, INIT_B);
        else            chk(hi_run >= RP_B, "R5 precharge", hi_run, RP_B);
        if (b2b_win) begin
          if (b2b_n > 0) chk(hi_run == GAP_B, "R8 back-to-back gap", hi_run, GAP_B);
          b2b_n++;
        end
        if (rnd_on) rnd_falls++;
        if (!ready) falls_pre_ready++;
        first_fall = 0;
      end
      if (r && !prev_r) chk(lo_run == RAS_B, "R5 row strobe width", lo_run, RAS_B);
      if (!c && prev_c) chk(hi_run >= CPN_B, "R3 column precharge", hi_run, CPN_B);
      if (c && !prev_c) begin
        chk(both == CHR_B, "R4 column hold after row", both, CHR_B);
        chk(!r, "R4 column rises under low row", int'(r), 0);
      end
      if (ready && !seen_ready) begin
        seen_ready = 1;
        chk(falls_pre_ready == PRIME_B, "R2 priming count", falls_pre_ready, PRIME_B);
        chk(hi_run == RP_B, "R2 ready after last precharge", hi_run, RP_B);
      end else if (seen_ready && !ready) begin
        chk(0, "R2 ready fell", 0, 1);
      end
      if (r) begin hi_run++; lo_run = 0; end
      else   begin lo_run++; hi_run = 0; end
      if (!c && r) cas_lo++; else cas_lo = 0;
      if (!c && !r) both++; else both = 0;
      prev_r = r; prev_c = c; prev_req = ref_req;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    chk(0, "watchdog expired", cyc, WD_CYCLES);
    finish_run();
  end

  initial begin
    int left;
    int guard;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(ras_n == {LINES{1'b1}}, "R9 reset row strobes", int'(ras_n), (1 << LINES) - 1);
    chk(cas_n == {LINES{1'b1}}, "R9 reset column strobes", int'(cas_n), (1 << LINES) - 1);
    chk(we_n == 1'b1, "R9 reset we_n", int'(we_n), 1);
    chk(!ref_req && !ref_own && !ready, "R9 reset flags",
        int'({ref_req, ref_own, ready}), 0);
    rst_n = 1'b1;

    // Power-up sequence.
    guard = 0;
    while (!ready && guard < 5000) begin @(negedge clk); guard++; end
    chk(ready, "R2 ready reached", int'(ready), 1);

    // Withhold the grant over more than four refresh slots.
    @(posedge clk); #2 hold = 1'b1;
    guard = 0;
    while (!ref_req && guard < 3 * P_B) begin @(posedge clk); #2; guard++; end
    chk(ref_req, "R8 request after one slot", int'(ref_req), 1);
    repeat (5 * P_B + 20) @(posedge clk);
    #2;
    chk(!ref_own && ras_n == {LINES{1'b1}}, "R7 no refresh while grant withheld",
        int'(ras_n), (1 << LINES) - 1);
    b2b_win = 1; b2b_n = 0;
    hold = 1'b0;
    @(posedge clk); #2;
    guard = 0;
    while ((ref_req || ref_own) && guard < 400) begin @(posedge clk); #2; guard++; end
    @(negedge clk);
    chk(b2b_n == MAXBL_B, "R8 saturated backlog burst", b2b_n, MAXBL_B);
    b2b_win = 0;

    // Random access traffic over forty refresh slots.
    rnd_on = 1; rnd_falls = 0;
    left = 0;
    for (int i = 0; i < 40 * P_B; i++) begin
      @(posedge clk); #2;
      if (busy) begin
        left--;
        if (left <= 0) busy = 1'b0;
      end else if (!ref_req && !ref_own && $urandom_range(0, 3) == 0) begin
        busy = 1'b1;
        left = $urandom_range(1, 40);
      end
    end
    @(posedge clk); #2 busy = 1'b0;
    rnd_on = 0;
    chk(rnd_falls >= 39 && rnd_falls <= 41, "R8 refresh rate under traffic", rnd_falls, 40);
    repeat (20) @(negedge clk);
    chk(ready, "R2 ready still high", int'(ready), 1);
    finish_run();
  end
endmodule